// File: doc/BRIEF.md
# Programmable Pseudo-Noise Sequencer with Subsampling Clock Divider

This block produces a pseudo-noise bit stream from a linear feedback shift register whose length and feedback polynomial are set at run time. Next to it runs an integer clock divider that makes the subsampling clock for an acquisition path. All outputs come from state that updates only on the rising edge of the main clock. An external alignment input resynchronizes the block: on its falling edge the shift register and the divider both restart from their start states. Many channels that share one alignment line therefore stay phase-locked to each other.

Software writes the sequence length, the feedback tap mask, the start value and the divide ratio into staging registers through a narrow write port. The staged values are copied into the running configuration only at reset or on an alignment event, so a running sequence is never disturbed in the middle. A sequence-start pulse marks each return of the register to its start value. A warning flag is raised when the divide ratio divides the sequence length 2^order - 1. Equivalent-time subsampling fails in that case.

Top module: `pn_divgen_top`

## Requirements
- R1: A write to address 0 stages the register length; values below 2 are stored as 2 and values above 24 are stored as 24.
- R2: A write to address 1 stages the tap mask, bit i meaning state bit i feeds back. Each cycle the state shifts one place toward its top bit and the XOR of (state AND taps) enters bit 0. Only the low `order` bits are kept. `pn_out` shows state bit order-1.
- R3: A write to address 3 stages the divide ratio S, clamped into 8..1048583; the divider counts 0..S-1 and wraps, giving a period of S cycles.
- R4: A write to address 2 stages the start value; it is masked to the low `order` bits, and a start value that is zero after masking is replaced by 1.
- R5: `sync_in` passes through two synchronizer flops; a falling edge loads the start value into the register and clears the divider count at the third rising clock edge after the fall; a rising edge has no effect.
- R6: `div_clk` is high while the divider count is below floor(S/2) and low for the rest of each period, so it is high at count 0.
- R7: `period_start` is high in exactly those cycles in which the register state equals the active start value.
- R8: Within 30 cycles after a configuration becomes active, `cfg_warn` equals 1 when (2^order - 1) mod S is 0 and 0 otherwise; it stays 0 while that test is still running.
- R9: Staged writes change nothing until the next alignment event or reset. Reset leaves order 7, taps 0x60, start value 1 and ratio 8 both staged and active, with the state equal to the start value and the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Staging register write enable |
| cfg_addr | input | 2 | Staging register select: 0 order, 1 taps, 2 start value, 3 ratio |
| cfg_wdata | input | 32 | Write data |
| sync_in | input | 1 | Asynchronous alignment input, falling edge active |
| pn_out | output | 1 | Pseudo-noise bit |
| div_clk | output | 1 | Divided subsampling clock |
| period_start | output | 1 | High while the state equals the start value |
| cfg_warn | output | 1 | Divide ratio divides the sequence length |

## Verification
The hardest situation to reach is a warning-flag case, because a random order and ratio almost never make S divide 2^order - 1. The bench therefore adds directed pairs whose ratio is a known divisor, such as order 6 with S = 9 and order 4 with S = 15. A second hard case is the handover at an alignment fall. The old sequence must keep running through the two synchronizer cycles, and the new one must start exactly at the third edge. The bench drives the fall at a known falling clock edge and compares every cycle on both sides of the load against its own model.

// File: rtl/pngen_pkg.sv
package pngen_pkg;

    localparam int unsigned MAX_ORDER = 24;
    localparam int unsigned MIN_ORDER = 2;
    localparam int unsigned ORD_W     = $clog2(MAX_ORDER + 1);
    localparam int unsigned MIN_RATIO = 8;
    localparam int unsigned MAX_RATIO = 1048583;
    localparam int unsigned DIV_W     = $clog2(MAX_RATIO + 1);
    localparam int unsigned WDATA_W   = 32;

    typedef logic [MAX_ORDER-1:0] word_t;
    typedef logic [DIV_W-1:0]     ratio_t;
    typedef logic [ORD_W-1:0]     order_t;
    typedef logic [WDATA_W-1:0]   wdata_t;

    typedef enum logic [1:0] {
        REG_ORDER = 2'd0,
        REG_TAPS  = 2'd1,
        REG_START = 2'd2,
        REG_RATIO = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        order_t order;
        word_t  taps;
        word_t  seed;
        ratio_t ratio;
    } pn_cfg_t;

    function automatic word_t order_mask(order_t o);
        word_t m;
        m = '0;
        for (int i = 0; i < int'(MAX_ORDER); i++) begin
            if (i < int'(o)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic order_t clamp_order(wdata_t v);
        if (v < WDATA_W'(MIN_ORDER)) return order_t'(MIN_ORDER);
        if (v > WDATA_W'(MAX_ORDER)) return order_t'(MAX_ORDER);
        return v[ORD_W-1:0];
    endfunction

    function automatic ratio_t clamp_ratio(wdata_t v);
        if (v < WDATA_W'(MIN_RATIO)) return ratio_t'(MIN_RATIO);
        if (v > WDATA_W'(MAX_RATIO)) return ratio_t'(MAX_RATIO);
        return v[DIV_W-1:0];
    endfunction

    function automatic pn_cfg_t sanitize(pn_cfg_t c);
        pn_cfg_t r;
        word_t   m;
        m      = order_mask(c.order);
        r      = c;
        r.taps = c.taps & m;
        r.seed = c.seed & m;
        if (r.seed == '0) r.seed = word_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/pn_sync_fall.sv
module pn_sync_fall #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sf_state_t;

    sf_state_t st_d, st_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                st_d      = st_q;
                st_d.pipe = {st_q.pipe[STAGES-2:0], async_in};
                st_d.prev = st_q.pipe[STAGES-1];
            end
        end else begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.pipe = async_in;
                st_d.prev = st_q.pipe[0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall = st_q.prev & ~st_q.pipe[STAGES-1];

    // R5: a detected fall cannot repeat on the next cycle
    p_single_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core
    import pngen_pkg::*;
#(
    parameter word_t RST_SEED = word_t'(1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  word_t  seed,
    input  order_t order,
    input  word_t  taps,
    output word_t  state_q
);
    word_t state_d;
    logic  fb;

    always_comb begin
        fb = ^(state_q & taps);
        if (load) state_d = seed;
        else      state_d = {state_q[MAX_ORDER-2:0], fb} & order_mask(order);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_SEED;
        else        state_q <= state_d;
    end

    // R5: the start value is in the register one cycle after a load
    p_seed_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == $past(seed)));

    // R2: no state bit above the active length is ever set after a step
    p_state_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((state_q & ~order_mask($past(order))) == '0));

endmodule

// File: rtl/pn_ratio_div.sv
module pn_ratio_div
    import pngen_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  ratio_t ratio,
    output logic   div_clk
);
    typedef struct packed {
        ratio_t cnt;
        logic   hi;
    } dv_state_t;

    dv_state_t st_d, st_q;
    ratio_t    half;

    always_comb begin
        half = ratio >> 1;
        st_d = st_q;
        if (load || (st_q.cnt == ratio - ratio_t'(1))) st_d.cnt = '0;
        else                                           st_d.cnt = st_q.cnt + ratio_t'(1);
        st_d.hi = (st_d.cnt < half);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.hi  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk = st_q.hi;

    // R3: the count stays inside one period
    p_cnt_below_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> (st_q.cnt < ratio));

    // R6: the output is high at the start of a period
    p_high_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> st_q.hi);

    // R6: the output is low in the last cycle of a period
    p_low_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && st_q.cnt == ratio - ratio_t'(1)) |-> !st_q.hi);

endmodule

// File: rtl/pn_ratio_check.sv
module pn_ratio_check
    import pngen_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  order_t order,
    input  ratio_t ratio,
    output logic   warn
);
    typedef struct packed {
        logic           busy;
        order_t         left;
        logic [DIV_W:0] rem;
        ratio_t         ratio;
        logic           warn;
    } ck_state_t;

    ck_state_t      st_d, st_q;
    logic [DIV_W:0] trial;

    always_comb begin
        st_d  = st_q;
        trial = {st_q.rem[DIV_W-1:0], 1'b1};
        if (trial >= {1'b0, st_q.ratio}) trial = trial - {1'b0, st_q.ratio};
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.left  = order;
            st_d.rem   = '0;
            st_d.ratio = ratio;
            st_d.warn  = 1'b0;
        end else if (st_q.busy) begin
            if (st_q.left == '0) begin
                st_d.busy = 1'b0;
                st_d.warn = (st_q.rem == '0);
            end else begin
                st_d.rem  = trial;
                st_d.left = st_q.left - order_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warn = st_q.warn;

    // R8: the flag stays low while the test runs
    p_warn_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !st_q.warn);

    // R8: the partial remainder stays below the ratio under test
    p_rem_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.rem < {1'b0, st_q.ratio}));

endmodule

// File: rtl/pn_divgen_top.sv
module pn_divgen_top
    import pngen_pkg::*;
#(
    parameter int unsigned DEF_ORDER   = 7,
    parameter int unsigned DEF_TAPS    = 24'h000060,
    parameter int unsigned DEF_SEED    = 1,
    parameter int unsigned DEF_RATIO   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        sync_in,
    output logic        pn_out,
    output logic        div_clk,
    output logic        period_start,
    output logic        cfg_warn
);
    localparam pn_cfg_t DEF_CFG = '{
        order: order_t'(DEF_ORDER),
        taps:  word_t'(DEF_TAPS),
        seed:  word_t'(DEF_SEED),
        ratio: ratio_t'(DEF_RATIO)
    };

    typedef struct packed {
        pn_cfg_t staged;
        pn_cfg_t active;
        logic    init;
    } top_state_t;

    top_state_t st_d, st_q;
    pn_cfg_t    cfg_use;
    logic       apply;
    word_t      lfsr_state;

    pn_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .fall     (apply)
    );

    always_comb begin
        st_d      = st_q;
        st_d.init = 1'b0;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_addr))
                REG_ORDER: st_d.staged.order = clamp_order(cfg_wdata);
                REG_TAPS:  st_d.staged.taps  = cfg_wdata[MAX_ORDER-1:0];
                REG_START: st_d.staged.seed  = cfg_wdata[MAX_ORDER-1:0];
                default:   st_d.staged.ratio = clamp_ratio(cfg_wdata);
            endcase
        end
        if (apply) st_d.active = sanitize(st_q.staged);
        cfg_use = apply ? sanitize(st_q.staged) : st_q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.staged <= DEF_CFG;
            st_q.active <= sanitize(DEF_CFG);
            st_q.init   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    pn_lfsr_core #(.RST_SEED(sanitize(DEF_CFG).seed)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (apply),
        .seed    (cfg_use.seed),
        .order   (st_q.active.order),
        .taps    (st_q.active.taps),
        .state_q (lfsr_state)
    );

    pn_ratio_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (apply),
        .ratio   (cfg_use.ratio),
        .div_clk (div_clk)
    );

    pn_ratio_check u_check (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_q.init | apply),
        .order (cfg_use.order),
        .ratio (cfg_use.ratio),
        .warn  (cfg_warn)
    );

    assign pn_out       = lfsr_state[st_q.active.order - order_t'(1)];
    assign period_start = (lfsr_state == st_q.active.seed);

    // R9: the running configuration changes only on an alignment event
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(st_q.active));

    // R1: the active length stays inside its legal range
    p_order_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active.order >= order_t'(MIN_ORDER)) && (st_q.active.order <= order_t'(MAX_ORDER)));

    // R4: the active start value is never zero
    p_seed_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active.seed != '0);

endmodule

// File: tb/pn_divgen_top_tb.sv
module pn_divgen_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        sync_in = 1'b1;
    logic        pn_out, div_clk, period_start, cfg_warn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned m_order, m_taps, m_seed, m_ratio, m_state, m_cnt;
    int unsigned s_order, s_taps, s_seed, s_ratio;

    pn_divgen_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .sync_in      (sync_in),
        .pn_out       (pn_out),
        .div_clk      (div_clk),
        .period_start (period_start),
        .cfg_warn     (cfg_warn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unsigned b_mask(int unsigned o);
        return (32'd1 << o) - 32'd1;
    endfunction

    function automatic int unsigned b_clamp_order(int unsigned v);
        if (v < 2) return 2;
        if (v > 24) return 24;
        return v;
    endfunction

    function automatic int unsigned b_clamp_ratio(int unsigned v);
        if (v < 8) return 8;
        if (v > 1048583) return 1048583;
        return v;
    endfunction

    function automatic int unsigned b_next(int unsigned st, int unsigned tp, int unsigned o);
        int unsigned fb;
        fb = $countones(st & tp) % 2;
        return ((st << 1) | fb) & b_mask(o);
    endfunction

    task automatic cmp(string req, string what, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string pt, string dt);
        cmp(pt, "pn_out", int'(pn_out), (m_state >> (m_order - 1)) & 1);
        cmp("R7", "period_start", int'(period_start), int'(m_state == m_seed));
        cmp(dt, "div_clk", int'(div_clk), int'(m_cnt < m_ratio / 2));
    endtask

    task automatic step_model();
        m_state = b_next(m_state, m_taps, m_order);
        m_cnt   = (m_cnt == m_ratio - 1) ? 0 : m_cnt + 1;
    endtask

    task automatic apply_model();
        m_order = s_order;
        m_taps  = s_taps & b_mask(s_order);
        m_seed  = s_seed & b_mask(s_order);
        if (m_seed == 0) m_seed = 1;
        m_ratio = s_ratio;
        m_state = m_seed;
        m_cnt   = 0;
    endtask

    task automatic cycle(string pt, string dt);
        @(posedge clk);
        @(negedge clk);
        step_model();
        compare_all(pt, dt);
    endtask

    task automatic run(int n, string pt, string dt);
        for (int i = 0; i < n; i++) cycle(pt, dt);
    endtask

    task automatic cfg_write(int unsigned a, int unsigned d);
        cfg_we    = 1'b1;
        cfg_addr  = a[1:0];
        cfg_wdata = d;
        case (a)
            0: s_order = b_clamp_order(d);
            1: s_taps  = d & 32'hFFFFFF;
            2: s_seed  = d & 32'hFFFFFF;
            default: s_ratio = b_clamp_ratio(d);
        endcase
        cycle("R9", "R9");
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(int unsigned o, int unsigned t, int unsigned s, int unsigned r);
        cfg_write(0, o);
        cfg_write(1, t);
        cfg_write(2, s);
        cfg_write(3, r);
    endtask

    task automatic do_sync(string pt, string dt);
        sync_in = 1'b0;
        cycle("R5", "R5");
        cycle("R5", "R5");
        @(posedge clk);
        @(negedge clk);
        apply_model();
        compare_all("R5", "R5");
        cmp("R5", "period_start_at_load", int'(period_start), 1);
        sync_in = 1'b1;
        run(2, pt, dt);
    endtask

    task automatic check_warn();
        int unsigned n;
        n = b_mask(m_order);
        cmp("R8", "cfg_warn", int'(cfg_warn), int'((n % m_ratio) == 0));
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        s_order = 7; s_taps = 32'h60; s_seed = 1; s_ratio = 8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply_model();
        // R9: reset state
        compare_all("R9", "R9");
        cmp("R8", "cfg_warn_during_test", int'(cfg_warn), 0);
        run(300, "R2", "R6");
        check_warn();

        // R9: staged writes ignored until alignment; rising sync ignored (R5)
        set_cfg(6, 32'h30, 32'h15, 9);
        sync_in = 1'b1;
        run(50, "R9", "R9");
        check_warn();
        do_sync("R2", "R3");
        run(60, "R2", "R3");
        check_warn();

        // R1 R3 R4: clamps low and zero start value
        set_cfg(1, 32'h3, 0, 3);
        run(5, "R9", "R9");
        do_sync("R1", "R3");
        run(40, "R4", "R3");
        check_warn();

        // R1 R3: clamps high
        set_cfg(40, 32'hE10000, 32'hABCDEF, 32'hFFFFFFFF);
        run(5, "R9", "R9");
        do_sync("R1", "R3");
        run(200, "R2", "R6");
        check_warn();

        // R8: directed divisor cases
        set_cfg(4, 32'hC, 5, 15);
        run(3, "R9", "R9");
        do_sync("R2", "R6");
        run(40, "R2", "R6");
        check_warn();
        cmp("R8", "cfg_warn_divisor", int'(cfg_warn), 1);
        set_cfg(8, 32'hB8, 32'h81, 17);
        run(3, "R9", "R9");
        do_sync("R2", "R6");
        run(60, "R2", "R6");
        check_warn();

        // random configurations
        for (int k = 0; k < 10; k++) begin
            int unsigned o, r;
            o = $urandom_range(24, 2);
            r = $urandom_range(60, 8);
            set_cfg(o, $urandom, ((k % 4) == 0) ? 0 : $urandom, r);
            run(3, "R9", "R9");
            do_sync("R2", "R6");
            run(150, "R2", "R6");
            check_warn();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule